// File: doc/BRIEF.md
# Galois-Form Pseudo-Random Sequence Generator

This block is an 8-bit linear feedback shift register that produces a pseudo-random word and a serial bit stream from the feedback polynomial x^8 + x^6 + x^5 + x^4 + 1. In its default form the register shifts toward the least significant stage. The bit that leaves stage 0 is XORed into every tapped stage in the same clock. No feedback path passes through more than one XOR gate, and the whole polynomial needs three two-input gates.

A parameter selects the equivalent Fibonacci arrangement instead. In that form the register shifts toward the most significant stage and a single parity of the tapped stages enters stage 0. Both forms visit all 255 non-zero states, so two instances can be run side by side and compared.

A load strobe writes a seed into every stage, and it takes priority over stepping. A zero seed is replaced with the safe value 8'h01, because the all-zero state would never leave itself. An enable input advances the register one step per clock. While the enable is low, the state holds.

Top module: `galois_lfsr_gen`

## Requirements
- R1: While rst_ni is low, and on the first clock after its release, state_o is 8'h01.
- R2: In the Galois form (FORM = LFSR_GALOIS), a step with load_i low gives next state = (state >> 1) XOR (state[0] ? 8'hB8 : 8'h00). The mask 8'hB8 marks stages 7, 5, 4 and 3.
- R3: In the Fibonacci form (FORM = LFSR_FIBONACCI), a step with load_i low gives next state = {state[6:0], state[7] ^ state[5] ^ state[4] ^ state[3]}.
- R4: With load_i and step_i both low, state_o keeps its value across the clock edge.
- R5: With load_i high and a non-zero seed_i, state_o equals seed_i after the edge, whatever step_i is.
- R6: With load_i high and seed_i equal to 8'h00, state_o becomes 8'h01 after the edge.
- R7: state_o is never 8'h00 once reset has been released.
- R8: Starting from any state, exactly 255 enabled steps return the register to that state, and no smaller number of steps does.
- R9: bit_o is the bit that leaves the register on the next step: state[0] in the Galois form and state[7] in the Fibonacci form.
- R10: Over one full period of 255 steps, bit_o is 1 on exactly 128 steps in either form.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Writes the seed into all stages; overrides step_i |
| seed_i | input | 8 | Seed value; zero is replaced with 8'h01 |
| step_i | input | 1 | Advances the register one position |
| state_o | output | 8 | Current register contents |
| bit_o | output | 1 | Serial bit leaving on the next step |

## Verification
Every change to state_o appears one clock after the rising edge at which load_i or step_i is sampled. bit_o is a combinational function of the stored state, so it changes in that same cycle. The bench drives its inputs at the falling edge. Its reference models update at the following rising edge, and the outputs are compared at the next falling edge, so each result is checked exactly one register delay after its stimulus. The period and balance checks count steps on the output itself and sample in that same falling-edge slot.

// File: rtl/lfsr_gen_pkg.sv
package lfsr_gen_pkg;

   typedef enum logic {
      LFSR_GALOIS    = 1'b0,
      LFSR_FIBONACCI = 1'b1
   } lfsr_form_e;

   // Counts the set bits of a tap mask (at most 64 stages considered).
   function automatic int unsigned tap_count(input logic [63:0] mask);
      int unsigned n;
      n = 0;
      for (int i = 0; i < 64; i++) begin
         n += int'(mask[i]);
      end
      return n;
   endfunction

endpackage

// File: rtl/lfsr_seed_guard.sv
// Replaces an all-zero seed with a safe non-zero value.
module lfsr_seed_guard #(
   parameter int unsigned      WIDTH     = 8,
   parameter logic [WIDTH-1:0] SAFE_SEED = 1
) (
   input  logic [WIDTH-1:0] seed_i,
   output logic [WIDTH-1:0] seed_o
);

   if (SAFE_SEED == '0) begin : g_bad_safe
      $error("lfsr_seed_guard: SAFE_SEED must be non-zero");
   end

   logic seed_zero;

   assign seed_zero = ~|seed_i;
   assign seed_o    = seed_zero ? SAFE_SEED : seed_i;

endmodule

// File: rtl/lfsr_galois_next.sv
// Galois step: shift toward stage 0; the leaving bit is XORed into every tapped stage at once.
module lfsr_galois_next #(
   parameter int unsigned      WIDTH = 8,
   parameter logic [WIDTH-1:0] MASK  = 8'hB8
) (
   input  logic [WIDTH-1:0] cur_i,
   output logic [WIDTH-1:0] nxt_o,
   output logic             out_o
);

   logic leave;

   assign leave = cur_i[0];
   assign out_o = leave;

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      if (i == WIDTH - 1) begin : g_top
         // The top stage has no upstream neighbour.
         assign nxt_o[i] = MASK[i] & leave;
      end else if (MASK[i]) begin : g_tap
         // A tapped stage gets its single XOR gate.
         assign nxt_o[i] = cur_i[i+1] ^ leave;
      end else begin : g_pass
         assign nxt_o[i] = cur_i[i+1];
      end
   end

endmodule

// File: rtl/lfsr_fib_next.sv
// Fibonacci step: shift toward the top stage; the parity of the taps enters stage 0.
module lfsr_fib_next #(
   parameter int unsigned      WIDTH = 8,
   parameter logic [WIDTH-1:0] MASK  = 8'hB8
) (
   input  logic [WIDTH-1:0] cur_i,
   output logic [WIDTH-1:0] nxt_o,
   output logic             out_o
);

   logic [WIDTH-1:0] tapped;
   logic             parity;

   assign tapped = cur_i & MASK;
   assign parity = ^tapped;
   assign out_o  = cur_i[WIDTH-1];
   assign nxt_o  = {cur_i[WIDTH-2:0], parity};

endmodule

// File: rtl/galois_lfsr_gen.sv
module galois_lfsr_gen
   import lfsr_gen_pkg::*;
#(
   parameter int unsigned      WIDTH      = 8,
   parameter logic [WIDTH-1:0] MASK       = 8'hB8,
   parameter logic [WIDTH-1:0] RESET_SEED = 1,
   parameter lfsr_form_e       FORM       = LFSR_GALOIS
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [WIDTH-1:0] seed_i,
   input  logic             step_i,
   output logic [WIDTH-1:0] state_o,
   output logic             bit_o
);

   localparam int unsigned TAPS      = tap_count(64'(MASK));
   localparam int unsigned XOR_GATES = TAPS - 1;

   if (WIDTH < 2 || WIDTH > 64) begin : g_bad_width
      $error("galois_lfsr_gen: WIDTH must be in 2..64");
   end
   if (RESET_SEED == '0) begin : g_bad_reset
      $error("galois_lfsr_gen: RESET_SEED must be non-zero");
   end
   if (!MASK[WIDTH-1]) begin : g_bad_mask
      $error("galois_lfsr_gen: MASK must include the top stage");
   end
   if (XOR_GATES < 1) begin : g_bad_taps
      $error("galois_lfsr_gen: MASK needs at least two taps");
   end

   logic [WIDTH-1:0] state_q;
   logic [WIDTH-1:0] state_d;
   logic [WIDTH-1:0] shifted;
   logic [WIDTH-1:0] seed_safe;
   logic             leave_bit;

   lfsr_seed_guard #(
      .WIDTH     (WIDTH),
      .SAFE_SEED (RESET_SEED)
   ) seed_guard_i (
      .seed_i (seed_i),
      .seed_o (seed_safe)
   );

   if (FORM == LFSR_GALOIS) begin : g_galois
      lfsr_galois_next #(
         .WIDTH (WIDTH),
         .MASK  (MASK)
      ) next_i (
         .cur_i (state_q),
         .nxt_o (shifted),
         .out_o (leave_bit)
      );
   end else begin : g_fibonacci
      lfsr_fib_next #(
         .WIDTH (WIDTH),
         .MASK  (MASK)
      ) next_i (
         .cur_i (state_q),
         .nxt_o (shifted),
         .out_o (leave_bit)
      );
   end

   // Load wins over step; otherwise hold.
   always_comb begin
      state_d = state_q;
      if (load_i) begin
         state_d = seed_safe;
      end else if (step_i) begin
         state_d = shifted;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= RESET_SEED;
      end else begin
         state_q <= state_d;
      end
   end

   assign state_o = state_q;
   assign bit_o   = leave_bit;

endmodule

// File: rtl/lfsr_gen_chk.sv
module lfsr_gen_chk
   import lfsr_gen_pkg::*;
#(
   parameter int unsigned      WIDTH      = 8,
   parameter logic [WIDTH-1:0] RESET_SEED = 1,
   parameter lfsr_form_e       FORM       = LFSR_GALOIS
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             load_i,
   input logic [WIDTH-1:0] seed_i,
   input logic             step_i,
   input logic [WIDTH-1:0] state_o,
   input logic             bit_o
);

   // R1
   reset_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> state_o == RESET_SEED);

   // R4
   hold_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !step_i) |=> $stable(state_o));

   // R5
   load_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && seed_i != '0) |=> state_o == $past(seed_i));

   // R6
   zero_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && seed_i == '0) |=> state_o == RESET_SEED);

   // R7
   never_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_o != '0);

   if (FORM == LFSR_GALOIS) begin : g_galois_chk
      // R2
      galois_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (step_i && !load_i) |=> state_o[WIDTH-1] == $past(bit_o));
   end else begin : g_fib_chk
      // R3
      fib_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (step_i && !load_i) |=> state_o[WIDTH-1:1] == $past(state_o[WIDTH-2:0]));
   end

endmodule

bind galois_lfsr_gen lfsr_gen_chk #(
   .WIDTH      (WIDTH),
   .RESET_SEED (RESET_SEED),
   .FORM       (FORM)
) chk_i (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .load_i  (load_i),
   .seed_i  (seed_i),
   .step_i  (step_i),
   .state_o (state_o),
   .bit_o   (bit_o)
);

// File: tb/galois_lfsr_gen_tb_top.sv
module galois_lfsr_gen_tb_top;
   import lfsr_gen_pkg::*;

   logic       clk = 1'b0;
   logic       rst_ni = 1'b0;
   logic       load_i = 1'b0;
   logic [7:0] seed_i = 8'h00;
   logic       step_i = 1'b0;
   logic [7:0] g_state, f_state;
   logic       g_bit, f_bit;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   logic [7:0] g_exp = 8'h01;
   logic [7:0] f_exp = 8'h01;

   always #2 clk = ~clk;

   galois_lfsr_gen #(.FORM(LFSR_GALOIS)) dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .seed_i(seed_i),
      .step_i(step_i), .state_o(g_state), .bit_o(g_bit));

   galois_lfsr_gen #(.FORM(LFSR_FIBONACCI)) dut_fib_i (
      .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .seed_i(seed_i),
      .step_i(step_i), .state_o(f_state), .bit_o(f_bit));

   function automatic logic [7:0] g_model(input logic [7:0] s);
      return (s >> 1) ^ (s[0] ? 8'hB8 : 8'h00);
   endfunction

   function automatic logic [7:0] f_model(input logic [7:0] s);
      return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got %0h expected %0h", req, got, exp);
      end
   endtask

   // Drive at the falling edge, let the rising edge act, compare at the next falling edge.
   task automatic tick(input logic ld, input logic [7:0] sd, input logic st);
      load_i = ld; seed_i = sd; step_i = st;
      @(posedge clk);
      if (ld) begin
         g_exp = (sd == 8'h00) ? 8'h01 : sd;
         f_exp = g_exp;
      end else if (st) begin
         g_exp = g_model(g_exp);
         f_exp = f_model(f_exp);
      end
      @(negedge clk);
   endtask

   task automatic cmp_both(input string rg, input string rf);
      chk(rg, 32'(g_state), 32'(g_exp));
      chk(rf, 32'(f_state), 32'(f_exp));
      chk("R9 galois bit", 32'(g_bit), 32'(g_exp[0]));
      chk("R9 fib bit", 32'(f_bit), 32'(f_exp[7]));
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles >= 100000) begin
         checks++;
         fails++;
         $display("FAIL R8 watchdog expired got %0d expected below %0d", cycles, 100000);
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 state held in reset
      chk("R1 galois in reset", 32'(g_state), 32'h01);
      chk("R1 fib in reset", 32'(f_state), 32'h01);
      rst_ni = 1'b1;
      @(negedge clk);
      cmp_both("R1 galois after release", "R1 fib after release");

      // R2 R3 R7 R9: walk beyond one period
      for (int i = 0; i < 300; i++) begin
         tick(1'b0, 8'h00, 1'b1);
         cmp_both("R2 galois step", "R3 fib step");
         chk("R7 galois nonzero", 32'(g_state != 8'h00), 32'h1);
         chk("R7 fib nonzero", 32'(f_state != 8'h00), 32'h1);
      end

      // R4 hold with several states
      for (int i = 0; i < 5; i++) begin
         tick(1'b0, 8'h00, 1'b1);
         for (int j = 0; j < 3; j++) begin
            tick(1'b0, 8'h5A, 1'b0);
            cmp_both("R4 galois hold", "R4 fib hold");
         end
      end

      // R5 R6 exhaustive seeds, loaded with step high, then one step
      for (int s = 0; s < 256; s++) begin
         tick(1'b1, 8'(s), 1'b1);
         if (s == 0) cmp_both("R6 galois zero seed", "R6 fib zero seed");
         else        cmp_both("R5 galois load", "R5 fib load");
         tick(1'b0, 8'h00, 1'b1);
         cmp_both("R2 galois step after load", "R3 fib step after load");
      end

      // R8 R10 period and balance from several start seeds
      for (int k = 0; k < 3; k++) begin
         logic [7:0] start;
         int g_len, f_len, g_ones, f_ones;
         logic g_done, f_done;
         start = (k == 0) ? 8'h01 : (k == 1) ? 8'hA7 : 8'hFF;
         tick(1'b1, start, 1'b0);
         g_len = 0; f_len = 0; g_ones = 0; f_ones = 0;
         g_done = 1'b0; f_done = 1'b0;
         for (int n = 0; n < 300; n++) begin
            if (!g_done) g_ones += int'(g_bit);
            if (!f_done) f_ones += int'(f_bit);
            tick(1'b0, 8'h00, 1'b1);
            if (!g_done) begin
               g_len++;
               if (g_state == start) g_done = 1'b1;
            end
            if (!f_done) begin
               f_len++;
               if (f_state == start) f_done = 1'b1;
            end
         end
         chk("R8 galois period", 32'(g_len), 32'd255);
         chk("R8 fib period", 32'(f_len), 32'd255);
         chk("R10 galois ones", 32'(g_ones), 32'd128);
         chk("R10 fib ones", 32'(f_ones), 32'd128);
      end

      summary();
   end

endmodule